// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks, with no limit on the ratio between them. Words are 18 bits wide by default and the depth is a power-of-two parameter. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchroniser. The flags that describe how much room is left (full, almost-full, half-full) are computed in the write domain. The flags that describe how much data is waiting (empty, almost-empty) are computed in the read domain.

A mode pin, sampled while master reset is held, selects one of two read behaviours. In standard mode a read request moves the next word into the output register, and the two status pins report empty and full. In first-word-fall-through mode the head word is presented without any request. In that mode the same two pins report output-ready and input-ready. A second pin, also sampled during master reset, picks one of two preset watermark offsets. The offsets can be reloaded afterwards, either in parallel over the write data bus or bit by bit over a serial input. Partial reset empties the buffer but keeps the offsets and the mode. Retransmit rewinds reading to the first stored location. An output enable releases the read data bus.

Back-pressure rules are as follows. On the write side, `wr_valid` offers a word and the word is taken on a write clock edge only when the buffer is not full. In fall-through mode `full_ir` is the ready signal. On the read side, a request made while no word is available is ignored.

Top module: `xclk_flag_fifo`

## Requirements
- R1: While `mrst_n` is low, and after it is released, the buffer holds no words. In standard mode `empty_or`=1, `full_ir`=0, `almost_empty`=1, `almost_full`=0 and `half_full`=0.
- R2: In standard mode, words come out in write order. The word appears on `rd_data` at the read clock edge that accepts `rd_req`, and `rd_data` holds its value while no read is made.
- R3: `full_ir` (standard mode) goes to 1 once DEPTH words are stored. A write offered while full is dropped, so draining returns exactly the first DEPTH words in order.
- R4: A read request while the buffer is empty (standard mode) leaves `rd_data` and the read position unchanged.
- R5: With `fwft_sel`=1 at master reset, `empty_or` means output-ready: it is 1 when the head word is on `rd_data` with no request made. `full_ir` means input-ready, which is the inverse of full. A request consumes the shown word and presents the next.
- R6: `half_full` is 1 exactly when the stored count exceeds DEPTH/2.
- R7: `almost_empty` is 1 exactly when the count on the read side is at or below the almost-empty offset. In fall-through mode this count includes the shown word.
- R8: `almost_full` is 1 exactly when the stored count is at or above DEPTH minus the almost-full offset.
- R9: After master reset both offsets equal OFF_A if `off_sel`=0, or OFF_B if `off_sel`=1.
- R10: While `ld`=1, each write strobe stores no data. The first strobe loads the almost-empty offset from `wr_data[AW-1:0]` and the second loads the almost-full offset. Dropping `ld` restarts this order.
- R11: While `sen`=1 (and `ld`=0), each write clock edge shifts `si` in, least significant bit first. The first AW bits form the almost-empty offset and the next AW bits form the almost-full offset. Dropping `sen` restarts the order.
- R12: A low pulse on `prst_n` empties the buffer but keeps both offsets and the selected mode.
- R13: A one-cycle `rt` pulse on the read clock rewinds reading to location 0, so the words written since the last reset are read again in order.
- R14: While `oe`=0 the data outputs are released to high impedance and do not present the stored word. They present it again when `oe` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, held across several edges of both clocks |
| prst_n | input | 1 | Partial reset, active low, keeps offsets and mode |
| fwft_sel | input | 1 | Timing mode, sampled during master reset (1 = fall-through) |
| off_sel | input | 1 | Preset offset choice, sampled during master reset |
| wr_valid | input | 1 | Write strobe / offered word |
| wr_data | input | W | Write data; low AW bits also carry parallel offsets |
| ld | input | 1 | Parallel offset load select |
| sen | input | 1 | Serial offset load enable |
| si | input | 1 | Serial offset data |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Count above DEPTH/2 |
| almost_full | output | 1 | Count at or above DEPTH minus almost-full offset |
| rd_req | input | 1 | Read request |
| rt | input | 1 | Retransmit pulse |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | W | Read data |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Read-side count at or below almost-empty offset |

## Verification
The bench builds the block with DEPTH=16, 18-bit words and preset offsets of 2 and 5. At these values every watermark boundary, the half-full step from 8 to 9 words, and the full condition can be reached with a handful of writes each. Each flag is checked after every single write while the buffer fills from empty to full. A 4-bit offset also keeps the serial load short at eight shifts. The write clock and the read clock run at different periods, so every flag is observed only after its pointer has crossed the synchronisers.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xcf_store.sv
module xcf_store #(
  parameter int W     = 18,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xcf_wside.sv
module xcf_wside
  import xcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFF_A = 7,
  parameter int OFF_B = 31,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int SCW  = $clog2(2 * AW) + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          rst,
  input  logic          fwft_pin,
  input  logic          sel_pin,
  input  logic          wr_valid,
  input  logic [AW-1:0] ld_val,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_ir,
  output logic          almost_full,
  output logic          half_full,
  output logic [AW-1:0] ae_off
);
  logic [PW-1:0]  wptr, wptr_nxt, rbin, wcnt;
  logic [AW-1:0]  af_off;
  logic [SCW-1:0] scnt;
  logic           mode_q, pidx, full;

  assign rbin     = PW'(gray_to_bin(32'(rgray_s)));
  assign wcnt     = wptr - rbin;
  assign full     = (wcnt == PW'(DEPTH));
  assign we       = wr_valid && !ld && !sen && !full;
  assign wptr_nxt = we ? wptr + PW'(1) : wptr;
  assign waddr    = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  // mode and watermark offsets: only master reset restores them
  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= fwft_pin;
      ae_off <= sel_pin ? AW'(OFF_B) : AW'(OFF_A);
      af_off <= sel_pin ? AW'(OFF_B) : AW'(OFF_A);
      pidx   <= 1'b0;
      scnt   <= '0;
    end else begin
      pidx <= ld ? (pidx ^ wr_valid) : 1'b0;
      if (ld && wr_valid) begin
        if (!pidx) ae_off <= ld_val;
        else       af_off <= ld_val;
      end
      if (!sen || ld)                  scnt <= '0;
      else if (scnt < SCW'(2 * AW))    scnt <= scnt + SCW'(1);
      if (sen && !ld) begin
        if (scnt < SCW'(AW))           ae_off <= {si, ae_off[AW-1:1]};
        else if (scnt < SCW'(2 * AW))  af_off <= {si, af_off[AW-1:1]};
      end
    end
  end

  assign full_ir     = mode_q ? !full : full;
  assign half_full   = (wcnt > PW'(DEPTH / 2));
  assign almost_full = (wcnt >= (PW'(DEPTH) - {1'b0, af_off}));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    wcnt <= PW'(DEPTH))
    else $error("stored count exceeds depth");

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_valid && !ld && !sen) |=> (wptr == $past(wptr)))
    else $error("write pointer moved while full");

  p_load_nostore_r10: assert property (@(posedge clk) disable iff (rst)
    (ld && wr_valid) |=> $stable(wptr))
    else $error("offset load stored a word");

  p_gray_step_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1)
    else $error("write gray code changed more than one bit");
endmodule

// File: rtl/xcf_rside.sv
module xcf_rside
  import xcf_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          rst,
  input  logic          fwft_pin,
  input  logic          rd_req,
  input  logic          rt,
  input  logic [PW-1:0] wgray_s,
  input  logic [W-1:0]  mem_q,
  input  logic [AW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  rd_q,
  output logic          empty_or,
  output logic          almost_empty
);
  logic [PW-1:0] rptr, rptr_nxt, wbin, ram_cnt, cnt;
  logic          mode_q, ovld, ram_empty, take;

  assign wbin      = PW'(gray_to_bin(32'(wgray_s)));
  assign ram_cnt   = wbin - rptr;
  assign ram_empty = (ram_cnt == '0);
  assign take      = !ram_empty && (mode_q ? (!ovld || rd_req) : rd_req);
  assign raddr     = rptr[AW-1:0];

  always_comb begin
    rptr_nxt = rptr;
    if (rt)        rptr_nxt = '0;
    else if (take) rptr_nxt = rptr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= fwft_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr  <= '0;
      rgray <= '0;
      rd_q  <= '0;
      ovld  <= 1'b0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= rptr_nxt ^ (rptr_nxt >> 1);
      if (rt) begin
        ovld <= 1'b0;
      end else if (take) begin
        rd_q <= mem_q;
        ovld <= 1'b1;
      end else if (rd_req) begin
        ovld <= 1'b0;
      end
    end
  end

  assign cnt          = ram_cnt + PW'(mode_q && ovld);
  assign almost_empty = (cnt <= {1'b0, ae_off});
  assign empty_or     = mode_q ? ovld : ram_empty;

  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && ram_empty && rd_req && !rt) |=> ($stable(rptr) && $stable(rd_q)))
    else $error("read while empty changed state");

  p_fwft_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q && ovld && !rd_req && !rt) |=> (ovld && $stable(rd_q)))
    else $error("shown word lost without a request");

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    ram_cnt <= PW'(DEPTH))
    else $error("read pointer passed write pointer");
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 64,
  parameter int OFF_A = 7,
  parameter int OFF_B = 31,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         fwft_sel,
  input  logic         off_sel,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         ld,
  input  logic         sen,
  input  logic         si,
  output logic         full_ir,
  output logic         half_full,
  output logic         almost_full,
  input  logic         rd_req,
  input  logic         rt,
  input  logic         oe,
  output logic [W-1:0] rd_data,
  output logic         empty_or,
  output logic         almost_empty
);
  logic          mrst, rst, we;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [W-1:0]  mem_q, rd_q;

  assign mrst = !mrst_n;
  assign rst  = !mrst_n || !prst_n;

  xcf_sync #(.N(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));
  xcf_sync #(.N(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));

  xcf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xcf_wside #(.DEPTH(DEPTH), .OFF_A(OFF_A), .OFF_B(OFF_B)) u_wside (
    .clk(wclk), .mrst(mrst), .rst(rst), .fwft_pin(fwft_sel), .sel_pin(off_sel),
    .wr_valid(wr_valid), .ld_val(wr_data[AW-1:0]), .ld(ld), .sen(sen), .si(si),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray), .full_ir(full_ir),
    .almost_full(almost_full), .half_full(half_full), .ae_off(ae_off)
  );

  xcf_rside #(.W(W), .DEPTH(DEPTH)) u_rside (
    .clk(rclk), .mrst(mrst), .rst(rst), .fwft_pin(fwft_sel), .rd_req(rd_req),
    .rt(rt), .wgray_s(wgray_s), .mem_q(mem_q), .ae_off(ae_off), .raddr(raddr),
    .rgray(rgray), .rd_q(rd_q), .empty_or(empty_or), .almost_empty(almost_empty)
  );

  assign rd_data = oe ? rd_q : 'z;
endmodule

// File: tb/xclk_flag_fifo_tb_top.sv
module xclk_flag_fifo_tb_top;
  localparam int W = 18;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, off_sel = 0;
  logic wr_valid = 0, ld = 0, sen = 0, si = 0;
  logic [W-1:0] wr_data = '0;
  logic rd_req = 0, rt = 0, oe = 1;
  logic full_ir, half_full, almost_full, empty_or, almost_empty;
  logic [W-1:0] rd_data;
  int errors = 0, checks = 0;

  always #2 wclk = ~wclk;  // 250 MHz
  always #3 rclk = ~rclk;

  xclk_flag_fifo #(.W(W), .DEPTH(DEPTH), .OFF_A(2), .OFF_B(5)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .off_sel(off_sel), .wr_valid(wr_valid), .wr_data(wr_data),
    .ld(ld), .sen(sen), .si(si), .full_ir(full_ir), .half_full(half_full),
    .almost_full(almost_full), .rd_req(rd_req), .rt(rt), .oe(oe),
    .rd_data(rd_data), .empty_or(empty_or), .almost_empty(almost_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_mreset(input logic mode, input logic sel);
    @(negedge rclk);
    mrst_n = 0; fwft_sel = mode; off_sel = sel;
    repeat (4) @(negedge rclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic do_preset();
    @(negedge rclk);
    prst_n = 0;
    repeat (4) @(negedge rclk);
    prst_n = 1;
    settle();
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wclk);
    wr_valid = 1; wr_data = d;
    @(negedge wclk);
    wr_valid = 0;
  endtask

  task automatic pop();
    @(negedge rclk);
    rd_req = 1;
    @(negedge rclk);
    rd_req = 0;
  endtask

  task automatic t_reset();
    do_mreset(1'b0, 1'b0);
    check("R1 empty", 32'(empty_or), 1);
    check("R1 full", 32'(full_ir), 0);
    check("R1 almost_empty", 32'(almost_empty), 1);
    check("R1 almost_full", 32'(almost_full), 0);
    check("R1 half_full", 32'(half_full), 0);
  endtask

  task automatic t_order();
    push(18'h1); push(18'h2); push(18'h3);
    settle();
    check("R2 not empty", 32'(empty_or), 0);
    pop(); check("R2 word0", 32'(rd_data), 32'h1);
    pop(); check("R2 word1", 32'(rd_data), 32'h2);
    pop(); check("R2 word2", 32'(rd_data), 32'h3);
    settle();
    check("R2 hold", 32'(rd_data), 32'h3);
    check("R2 empty after drain", 32'(empty_or), 1);
  endtask

  task automatic t_empty_read();
    pop();
    check("R4 data unchanged", 32'(rd_data), 32'h3);
    check("R4 still empty", 32'(empty_or), 1);
    push(18'h15);
    settle();
    pop();
    check("R4 next word intact", 32'(rd_data), 32'h15);
  endtask

  task automatic t_oe();
    @(negedge rclk); oe = 0;
    @(negedge rclk);
    check("R14 released", 32'(rd_data === 18'h15), 0);
    oe = 1;
    @(negedge rclk);
    check("R14 restored", 32'(rd_data), 32'h15);
  endtask

  task automatic t_fill();
    for (int k = 1; k <= DEPTH; k++) begin
      push(18'(32'h100 + k));
      settle();
      check("R7 almost_empty", 32'(almost_empty), 32'(k <= 2));
      check("R6 half_full", 32'(half_full), 32'(k > DEPTH / 2));
      check("R8 almost_full", 32'(almost_full), 32'(k >= DEPTH - 2));
      check("R3 full", 32'(full_ir), 32'(k == DEPTH));
    end
    push(18'h3ffff);
    settle();
    for (int k = 1; k <= DEPTH; k++) begin
      pop();
      check("R3 drain order", 32'(rd_data), 32'h100 + k);
    end
    settle();
    check("R3 extra write dropped", 32'(empty_or), 1);
  endtask

  task automatic t_preset_b();
    do_mreset(1'b0, 1'b1);
    for (int k = 1; k <= DEPTH - 5; k++) begin
      push(18'(k));
      settle();
      check("R9 ae with preset B", 32'(almost_empty), 32'(k <= 5));
      check("R9 af with preset B", 32'(almost_full), 32'(k >= DEPTH - 5));
    end
  endtask

  task automatic t_parallel();
    do_mreset(1'b0, 1'b0);
    @(negedge wclk); ld = 1;
    push(18'd3); push(18'd12);
    @(negedge wclk); ld = 0;
    settle();
    check("R10 no word stored", 32'(empty_or), 1);
    for (int k = 1; k <= 4; k++) begin
      push(18'(k));
      settle();
      check("R10 ae offset", 32'(almost_empty), 32'(k <= 3));
      check("R10 af offset", 32'(almost_full), 32'(k >= 4));
    end
  endtask

  task automatic t_partial();
    do_preset();
    check("R12 emptied", 32'(empty_or), 1);
    check("R12 half_full clear", 32'(half_full), 0);
    for (int k = 1; k <= 4; k++) begin
      push(18'(k));
      settle();
      check("R12 ae offset kept", 32'(almost_empty), 32'(k <= 3));
      check("R12 af offset kept", 32'(almost_full), 32'(k >= 4));
    end
  endtask

  task automatic t_serial();
    logic [7:0] bits;
    bits = {4'd6, 4'd1};  // almost-empty 1, almost-full 6
    for (int i = 0; i < 8; i++) begin
      @(negedge wclk); sen = 1; si = bits[i];
    end
    @(negedge wclk); sen = 0; si = 0;
    do_preset();
    for (int k = 1; k <= 10; k++) begin
      push(18'(k));
      settle();
      check("R11 serial ae", 32'(almost_empty), 32'(k <= 1));
      check("R11 serial af", 32'(almost_full), 32'(k >= 10));
    end
  endtask

  task automatic t_retransmit();
    do_preset();
    for (int k = 0; k < 4; k++) push(18'(32'h200 + k));
    settle();
    pop(); check("R13 first pass 0", 32'(rd_data), 32'h200);
    pop(); check("R13 first pass 1", 32'(rd_data), 32'h201);
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    settle();
    for (int k = 0; k < 4; k++) begin
      pop();
      check("R13 replay", 32'(rd_data), 32'h200 + k);
    end
    settle();
    check("R13 empty after replay", 32'(empty_or), 1);
  endtask

  task automatic t_fwft();
    do_mreset(1'b1, 1'b0);
    check("R5 output-ready low", 32'(empty_or), 0);
    check("R5 input-ready high", 32'(full_ir), 1);
    push(18'h11);
    settle();
    check("R5 fall-through ready", 32'(empty_or), 1);
    check("R5 fall-through word", 32'(rd_data), 32'h11);
    push(18'h22);
    settle();
    check("R5 word held", 32'(rd_data), 32'h11);
    pop();
    check("R5 next word", 32'(rd_data), 32'h22);
    check("R5 still ready", 32'(empty_or), 1);
    pop();
    check("R5 drained", 32'(empty_or), 0);
    push(18'h40);
    settle();
    for (int k = 1; k <= DEPTH; k++) push(18'(32'h40 + k));
    settle();
    check("R5 input-ready low when full", 32'(full_ir), 0);
    do_preset();
    check("R12 mode kept: not ready", 32'(empty_or), 0);
    check("R12 mode kept: input-ready", 32'(full_ir), 1);
    push(18'h33);
    settle();
    check("R12 mode kept: fall-through", 32'(rd_data), 32'h33);
  endtask

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_oe();
    t_fill();
    t_preset_b();
    t_parallel();
    t_partial();
    t_serial();
    t_retransmit();
    t_fwft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule